// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic engine for a small accumulator machine. Each time the execute strobe is high on a rising clock edge, it combines the held accumulator with a second operand and the held carry. It then writes a new accumulator value and new carry, zero, sign and parity flags. An operand may come from a register or from an immediate field; which one is decided outside the block. The accumulator and the flags live in a register stage inside the block.

Two families of operation share one select field. With the rotate enable low, a 3-bit code picks one of eight two-operand operations. With the rotate enable high, the low two bits of the same field pick one of four single-bit rotations of the accumulator. Two of these rotations wrap around on themselves and two pass through the carry. Instruction fetch, decoding and register-file access sit in the surrounding machine.

Top module: `acc_alu_unit`

## Requirements
- R1: With rotate enable low, operation code 000 writes accumulator plus operand and code 001 writes accumulator plus operand plus the held carry. Carry becomes the carry out of the top bit.
- R2: Code 010 writes accumulator minus operand and code 011 writes accumulator minus operand minus the held carry. Carry becomes 1 exactly when a borrow occurs, that is when the subtrahend, with the carry included for code 011, exceeds the unsigned accumulator. Codes 000 and 010 ignore the held carry.
- R3: Codes 100, 101 and 110 write the bitwise AND, XOR and OR of accumulator and operand, and clear the carry.
- R4: Code 111 (compare) forms accumulator minus operand, sets carry to the borrow and zero/sign/parity from that difference, and leaves the accumulator unchanged.
- R5: For codes 000 to 111, zero is 1 when the result is all zeros, sign equals the result's top bit, and parity is 1 when the result holds an even number of ones (0 when odd).
- R6: With rotate enable high, select 00 rotates left circularly (top bit to bit 0 and carry), and select 01 rotates right circularly (bit 0 to top bit and carry).
- R7: Select 10 rotates left through carry (old carry to bit 0, top bit to carry). Select 11 rotates right through carry (old carry to top bit, bit 0 to carry). The operand input is ignored for all rotations.
- R8: Rotations change only the accumulator and carry; zero, sign and parity keep their values.
- R9: When the execute strobe is low, the accumulator and all flags hold their values whatever the other inputs do.
- R10: A low reset at a rising edge clears the accumulator and all four flags, and takes priority over the execute strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_en | input | 1 | Execute strobe: apply one operation at this edge |
| rot_en | input | 1 | 1 selects a rotation, 0 a two-operand operation |
| op_sel | input | 3 | Operation code, or rotation select in bits 1:0 |
| operand | input | DATA_W | Second operand (register or immediate) |
| acc_q | output | DATA_W | Held accumulator |
| flag_c | output | 1 | Carry / borrow flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_p | output | 1 | Parity flag, 1 for even |

## Verification
The bench builds the block with its default width of DATA_W = 8. At that width, hand-computed vectors reach every interesting edge of the datapath: carry out of 0xFF + 0x01, a carry-in that alone wraps 0x7F + 0x80 to zero, borrows through zero with and without a carry-in, and results with odd and even parity. The vectors also give rotations whose bit moved into the carry differs from the bit moved out. The same width lets the bench set up any accumulator value with a chosen carry using only the block's own operations. It then checks that compare and rotations leave untouched the state they must keep.

// File: rtl/acc_alu_pkg.sv
// Package: shared encodings and the flag bundle for the accumulator ALU.
// Assumes: operation and rotate codes are fixed by the surrounding decoder.
package acc_alu_pkg;

    // Two-operand operation codes; the numeric values are decoded upstream.
    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_ADC = 3'b001,
        OP_SUB = 3'b010,
        OP_SBB = 3'b011,
        OP_AND = 3'b100,
        OP_XOR = 3'b101,
        OP_OR  = 3'b110,
        OP_CMP = 3'b111
    } alu_op_e;

    // Rotation selects carried in the low two bits of the operation field.
    typedef enum logic [1:0] {
        ROT_LEFT_CIRC  = 2'b00,
        ROT_RIGHT_CIRC = 2'b01,
        ROT_LEFT_THRU  = 2'b10,
        ROT_RIGHT_THRU = 2'b11
    } rot_sel_e;

    // Status bundle held next to the accumulator.
    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic p;
    } flags_t;

    localparam flags_t FLAGS_CLEAR = '{c: 1'b0, z: 1'b0, s: 1'b0, p: 1'b0};

endpackage

// File: rtl/acc_alu_arith.sv
// Module: two-operand arithmetic and logic core.
// Does: computes add, add-with-carry, subtract, subtract-with-borrow, AND,
//       XOR, OR and compare on DATA_W bits, plus all four result flags and
//       whether the accumulator should take the result.
// Assumes: purely combinational; the carry input is the held carry flag.
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              [DATA_W-1:0] acc_i,
    input  logic              [DATA_W-1:0] opnd_i,
    input  logic                           carry_i,
    input  alu_op_e                        op_i,
    output logic              [DATA_W-1:0] result_o,
    output logic                           acc_wr_o,
    output flags_t                         flags_o
);

    localparam int EXT_W = DATA_W + 1;

    logic             uses_carry;
    logic [EXT_W-1:0] cin_ext;
    logic [EXT_W-1:0] sum_ext;
    logic [EXT_W-1:0] dif_ext;
    logic             carry_n;

    // Select whether the held carry participates in this operation.
    always_comb begin
        uses_carry = (op_i == OP_ADC) || (op_i == OP_SBB);
        cin_ext    = {{DATA_W{1'b0}}, uses_carry & carry_i};
    end

    // Form the widened sum and difference; the extra bit is carry or borrow.
    always_comb begin
        sum_ext = {1'b0, acc_i} + {1'b0, opnd_i} + cin_ext;
        dif_ext = {1'b0, acc_i} - {1'b0, opnd_i} - cin_ext;
    end

    // Pick the result and the carry for the requested operation.
    always_comb begin
        result_o = '0;
        carry_n  = 1'b0;
        unique case (op_i)
            OP_ADD, OP_ADC: begin
                result_o = sum_ext[DATA_W-1:0];
                carry_n  = sum_ext[DATA_W];
            end
            OP_SUB, OP_SBB, OP_CMP: begin
                result_o = dif_ext[DATA_W-1:0];
                carry_n  = dif_ext[DATA_W];
            end
            OP_AND: result_o = acc_i & opnd_i;
            OP_XOR: result_o = acc_i ^ opnd_i;
            OP_OR:  result_o = acc_i | opnd_i;
            default: begin
                result_o = '0;
                carry_n  = 1'b0;
            end
        endcase
    end

    // Derive the status bundle and the accumulator write decision.
    always_comb begin
        flags_o.c = carry_n;
        flags_o.z = (result_o == '0);
        flags_o.s = result_o[DATA_W-1];
        flags_o.p = ~^result_o;
        acc_wr_o  = (op_i != OP_CMP);
    end

    // Cross-check borrow against an ordered comparison of the operands.
    always_comb begin
        if (!$isunknown({acc_i, opnd_i, op_i})) begin
            if (op_i == OP_SUB || op_i == OP_CMP) begin
                AST_SUB_BORROW: assert (flags_o.c == (opnd_i > acc_i)); // R2
            end
        end
    end

endmodule

// File: rtl/acc_alu_rotate.sv
// Module: single-bit accumulator rotator.
// Does: rotates the accumulator one place left or right, either around
//       itself or through the carry, and returns the new carry.
// Assumes: purely combinational; the operand input plays no part.
module acc_alu_rotate
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic     [DATA_W-1:0] acc_i,
    input  logic                  carry_i,
    input  rot_sel_e              sel_i,
    output logic     [DATA_W-1:0] result_o,
    output logic                  carry_o
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] left_core;
    logic [DATA_W-1:0] right_core;
    logic              fill_left;
    logic              fill_right;

    // Choose the bit that enters at each end: the wrapped bit or the carry.
    always_comb begin
        fill_left  = (sel_i == ROT_LEFT_THRU)  ? carry_i : acc_i[MSB];
        fill_right = (sel_i == ROT_RIGHT_THRU) ? carry_i : acc_i[0];
    end

    // Build the two shifted words bit by bit.
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_shift
        if (gi == 0) begin : g_lo
            assign left_core[gi]  = fill_left;
            assign right_core[gi] = acc_i[gi+1];
        end else if (gi == MSB) begin : g_hi
            assign left_core[gi]  = acc_i[gi-1];
            assign right_core[gi] = fill_right;
        end else begin : g_mid
            assign left_core[gi]  = acc_i[gi-1];
            assign right_core[gi] = acc_i[gi+1];
        end
    end

    // Pick direction and the bit that leaves into the carry.
    always_comb begin
        if (sel_i == ROT_LEFT_CIRC || sel_i == ROT_LEFT_THRU) begin
            result_o = left_core;
            carry_o  = acc_i[MSB];
        end else begin
            result_o = right_core;
            carry_o  = acc_i[0];
        end
    end

    // A rotation neither creates nor destroys ones across word plus carry.
    always_comb begin
        if (!$isunknown({acc_i, carry_i, sel_i})) begin
            if (sel_i == ROT_LEFT_THRU || sel_i == ROT_RIGHT_THRU) begin
                AST_ROT_KEEPS_ONES: assert ($countones({result_o, carry_o}) == $countones({acc_i, carry_i})); // R7
            end else begin
                AST_CIRC_KEEPS_WORD: assert ($countones(result_o) == $countones(acc_i)); // R6
            end
        end
    end

endmodule

// File: rtl/acc_alu_state.sv
// Module: accumulator and flag register stage.
// Does: holds the accumulator and four flags; on an execute edge loads the
//       accumulator if told to, always loads carry, and loads zero/sign/
//       parity only when told to.
// Assumes: synchronous active-low reset with priority over every load.
module acc_alu_state
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] acc_d,
    input  logic              zsp_wr,
    input  flags_t            flags_d,
    output logic [DATA_W-1:0] acc_q,
    output flags_t            flags_q
);

    // Accumulator register: cleared on reset, loaded on execute when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (exec_en && acc_wr) begin
            acc_q <= acc_d;
        end
    end

    // Carry register: every executed operation defines a new carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q.c <= 1'b0;
        end else if (exec_en) begin
            flags_q.c <= flags_d.c;
        end
    end

    // Zero/sign/parity registers: loaded only by value-producing operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q.z <= 1'b0;
            flags_q.s <= 1'b0;
            flags_q.p <= 1'b0;
        end else if (exec_en && zsp_wr) begin
            flags_q.z <= flags_d.z;
            flags_q.s <= flags_d.s;
            flags_q.p <= flags_d.p;
        end
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> ($stable(acc_q) && $stable(flags_q))); // R9

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (acc_q == '0 && flags_q == FLAGS_CLEAR)); // R10

endmodule

// File: rtl/acc_alu_unit.sv
// Module: accumulator ALU top.
// Does: steers the accumulator, operand and carry into either the arithmetic
//       core or the rotator, and commits the chosen result to the register
//       stage on the execute strobe.
// Assumes: op_sel is stable around the execute edge; for rotations only
//          op_sel[1:0] is used and the operand is ignored.
module acc_alu_unit
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  logic              rot_en,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc_q,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_s,
    output logic              flag_p
);

    alu_op_e           alu_op;
    rot_sel_e          rot_sel;
    logic [DATA_W-1:0] arith_res;
    logic              arith_wr;
    flags_t            arith_flags;
    logic [DATA_W-1:0] rot_res;
    logic              rot_carry;
    logic [DATA_W-1:0] next_acc;
    logic              next_acc_wr;
    logic              next_zsp_wr;
    flags_t            next_flags;
    flags_t            held_flags;

    // Interpret the shared select field for both datapaths.
    always_comb begin
        alu_op  = alu_op_e'(op_sel);
        rot_sel = rot_sel_e'(op_sel[1:0]);
    end

    acc_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .acc_i    (acc_q),
        .opnd_i   (operand),
        .carry_i  (held_flags.c),
        .op_i     (alu_op),
        .result_o (arith_res),
        .acc_wr_o (arith_wr),
        .flags_o  (arith_flags)
    );

    acc_alu_rotate #(.DATA_W(DATA_W)) u_rotate (
        .acc_i    (acc_q),
        .carry_i  (held_flags.c),
        .sel_i    (rot_sel),
        .result_o (rot_res),
        .carry_o  (rot_carry)
    );

    // Merge the two datapaths into one update for the register stage.
    always_comb begin
        if (rot_en) begin
            next_acc     = rot_res;
            next_acc_wr  = 1'b1;
            next_zsp_wr  = 1'b0;
            next_flags   = held_flags;
            next_flags.c = rot_carry;
        end else begin
            next_acc     = arith_res;
            next_acc_wr  = arith_wr;
            next_zsp_wr  = 1'b1;
            next_flags   = arith_flags;
        end
    end

    acc_alu_state #(.DATA_W(DATA_W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .exec_en (exec_en),
        .acc_wr  (next_acc_wr),
        .acc_d   (next_acc),
        .zsp_wr  (next_zsp_wr),
        .flags_d (next_flags),
        .acc_q   (acc_q),
        .flags_q (held_flags)
    );

    // Expose the held flags as individual pins.
    always_comb begin
        flag_c = held_flags.c;
        flag_z = held_flags.z;
        flag_s = held_flags.s;
        flag_p = held_flags.p;
    end

    AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && !rot_en && op_sel == 3'b111) |=> $stable(acc_q)); // R4

    AST_ROT_KEEPS_ZSP: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && rot_en) |=> ($stable(flag_z) && $stable(flag_s) && $stable(flag_p))); // R8

    AST_LOGIC_CLEARS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && !rot_en && op_sel[2] && op_sel != 3'b111) |=> !flag_c); // R3

    AST_ZERO_MATCHES_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && !rot_en && op_sel != 3'b111) |=> (flag_z == (acc_q == '0))); // R5

endmodule

// File: tb/test_acc_alu_unit.sv
module test_acc_alu_unit;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int NVEC = 20;
    localparam int WATCHDOG_CYCLES = 20000;

    typedef struct packed {
        logic       rot;
        logic [2:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic       cin;
        logic [7:0] exp_acc;
        logic       exp_c;
        logic [7:0] flag_src;
    } vec_t;

    // rot, op, start acc, operand, start carry, expected acc, expected carry,
    // value whose zero/sign/parity the flags must show afterwards
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 3'b000, 8'h12, 8'h34, 1'b0, 8'h46, 1'b0, 8'h46},
        '{1'b0, 3'b000, 8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 8'h00},
        '{1'b0, 3'b001, 8'h10, 8'h20, 1'b1, 8'h31, 1'b0, 8'h31},
        '{1'b0, 3'b001, 8'h7F, 8'h80, 1'b1, 8'h00, 1'b1, 8'h00},
        '{1'b0, 3'b010, 8'h50, 8'h20, 1'b1, 8'h30, 1'b0, 8'h30},
        '{1'b0, 3'b010, 8'h20, 8'h50, 1'b0, 8'hD0, 1'b1, 8'hD0},
        '{1'b0, 3'b011, 8'h50, 8'h20, 1'b1, 8'h2F, 1'b0, 8'h2F},
        '{1'b0, 3'b011, 8'h05, 8'h05, 1'b1, 8'hFF, 1'b1, 8'hFF},
        '{1'b0, 3'b100, 8'hF0, 8'h3C, 1'b1, 8'h30, 1'b0, 8'h30},
        '{1'b0, 3'b101, 8'hAA, 8'hFF, 1'b0, 8'h55, 1'b0, 8'h55},
        '{1'b0, 3'b110, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00},
        '{1'b0, 3'b111, 8'h40, 8'h41, 1'b0, 8'h40, 1'b1, 8'hFF},
        '{1'b0, 3'b111, 8'h41, 8'h41, 1'b1, 8'h41, 1'b0, 8'h00},
        '{1'b1, 3'b000, 8'h81, 8'h00, 1'b1, 8'h03, 1'b1, 8'h81},
        '{1'b1, 3'b001, 8'h81, 8'hFF, 1'b0, 8'hC0, 1'b1, 8'h81},
        '{1'b1, 3'b010, 8'h80, 8'h00, 1'b1, 8'h01, 1'b1, 8'h80},
        '{1'b1, 3'b011, 8'h01, 8'hAA, 1'b0, 8'h00, 1'b1, 8'h01},
        '{1'b1, 3'b010, 8'h40, 8'h00, 1'b0, 8'h80, 1'b0, 8'h40},
        '{1'b1, 3'b011, 8'h02, 8'h00, 1'b1, 8'h81, 1'b0, 8'h02},
        '{1'b0, 3'b011, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         exec_en = 1'b0;
    logic         rot_en = 1'b0;
    logic [2:0]   op_sel = 3'b000;
    logic [W-1:0] operand = '0;
    logic [W-1:0] acc_q;
    logic         flag_c, flag_z, flag_s, flag_p;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu_unit #(.DATA_W(W)) i_acc_alu_unit (
        .clk     (clk),
        .rst_n   (rst_n),
        .exec_en (exec_en),
        .rot_en  (rot_en),
        .op_sel  (op_sel),
        .operand (operand),
        .acc_q   (acc_q),
        .flag_c  (flag_c),
        .flag_z  (flag_z),
        .flag_s  (flag_s),
        .flag_p  (flag_p)
    );

    task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // One execute cycle; returns at the falling edge after the update.
    task automatic apply(input logic r, input logic [2:0] o, input logic [7:0] b);
        @(negedge clk);
        rot_en  = r;
        op_sel  = o;
        operand = b;
        exec_en = 1'b1;
        @(negedge clk);
        exec_en = 1'b0;
    endtask

    // Bring the accumulator to value a with carry cin (a must not be FF when cin=1).
    task automatic preload(input logic [7:0] a, input logic cin);
        apply(1'b0, 3'b100, 8'h00);
        if (cin) begin
            apply(1'b0, 3'b110, 8'hFF);
            apply(1'b0, 3'b000, a + 8'h01);
        end else begin
            apply(1'b0, 3'b110, a);
        end
    endtask

    function automatic string req_of(input vec_t v);
        if (v.rot) return (v.op[1] ? "R7" : "R6");
        case (v.op)
            3'b000, 3'b001: return "R1";
            3'b010, 3'b011: return "R2";
            3'b111:         return "R4";
            default:        return "R3";
        endcase
    endfunction

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "acc after reset", acc_q, 8'h00);
        check("R10", "flags after reset", {4'h0, flag_c, flag_z, flag_s, flag_p}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R1..R8 with flags derived per R5 (parity 1 = even)
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            string rq;
            v  = VECS[i];
            rq = req_of(v);
            preload(v.a, v.cin);
            apply(v.rot, v.op, v.b);
            check(rq, $sformatf("vec %0d acc", i), acc_q, v.exp_acc);
            check(rq, $sformatf("vec %0d carry", i), {7'h0, flag_c}, {7'h0, v.exp_c});
            check(v.rot ? "R8" : "R5", $sformatf("vec %0d zero", i), {7'h0, flag_z}, {7'h0, v.flag_src == 8'h00});
            check(v.rot ? "R8" : "R5", $sformatf("vec %0d sign", i), {7'h0, flag_s}, {7'h0, v.flag_src[7]});
            check(v.rot ? "R8" : "R5", $sformatf("vec %0d parity", i), {7'h0, flag_p}, {7'h0, ~^v.flag_src});
        end

        // R9: strobe low, inputs toggling, state must hold
        preload(8'h5A, 1'b1);
        @(negedge clk);
        rot_en = 1'b0; op_sel = 3'b000; operand = 8'h11;
        @(negedge clk);
        rot_en = 1'b1; op_sel = 3'b011;
        @(negedge clk);
        check("R9", "acc held", acc_q, 8'h5A);
        check("R9", "flags held", {4'h0, flag_c, flag_z, flag_s, flag_p}, {4'h0, 1'b1, 1'b0, 1'b0, 1'b1});

        // R10: reset beats a simultaneous execute
        @(negedge clk);
        rst_n = 1'b0; rot_en = 1'b0; op_sel = 3'b110; operand = 8'hFF; exec_en = 1'b1;
        @(negedge clk);
        exec_en = 1'b0; rst_n = 1'b1;
        check("R10", "acc after mid-run reset", acc_q, 8'h00);
        check("R10", "flags after mid-run reset", {4'h0, flag_c, flag_z, flag_s, flag_p}, 8'h00);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule